// File: doc/BRIEF.md
# Pulsed Output Group with Programmable Width

This block drives a group of output lines whose value lives in a data register. Each line can be a plain level or a one-shot pulse, chosen per line by a select register. Writing a 1 to the data bit of a pulse-type line raises the line and starts a countdown. When the countdown ends, the data bit clears itself, so reading the data register back shows which pulses are still running.

All lines in the group share one pulse-width code. The code uses decade-style steps from 1 ms to 100 s. Codes outside the legal range are dropped and the previous width stays in force. A millisecond tick, made by dividing the system clock by a parameter, paces every countdown. Each line keeps its own counter. That counter loads the width in force at the moment its pulse starts, so changing the code later does not stretch or shorten a pulse already in flight.

Software writes through a small register port. The port has a write strobe, a 2-bit register address and a data word. The data register, the select register and the width code read back on dedicated outputs.

Top module: `pulse_out_group`

## Requirements
- R1: Reset clears the data register, the select register and the width code, so `dout`, `sel_q` and `code_q` are all zero.
- R2: For a line whose select bit is 0, a write to address 0 sets `dout` for that line to the written bit. The new value is visible the cycle after the write and holds until the next data write.
- R3: For a line whose select bit is 1, writing 1 to address 0 raises that line the cycle after the write. After the pulse width it drops to 0 with no further write, and the data bit reads back as 0.
- R4: Width code 0..9, written to address 2 bits [3:0], gives 1, 10, 100, 1000, 2000, 5000, 10000, 20000, 50000 or 100000 ticks of high time. The code reads back on `code_q`.
- R5: A width-code write with a value of 10..15 leaves `code_q` unchanged.
- R6: Writing 1 again to a pulse line that is still high does not restart its countdown. The pulse ends at the time set by its first start.
- R7: Writing 0 to a pulse line that is still high ends its pulse in the cycle after the write.
- R8: A width-code change while a pulse is running does not change that pulse's length.
- R9: All pulse lines started by the same write end together, and level lines written in that same write stay unchanged.
- R10: Clearing a line's select bit during its pulse stops the countdown. The line keeps its current value as a level.
- R11: A write to address 3 changes none of `dout`, `sel_q` and `code_q`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 2 | Register address: 0 data, 1 select, 2 width code, 3 unused |
| wr_data | input | NBITS | Write data word; width code in bits [3:0] |
| dout | output | NBITS | Output lines, equal to the data register |
| sel_q | output | NBITS | Select register: 1 = pulse line, 0 = level line |
| code_q | output | 4 | Width code in force |

## Verification
The checker watches several rules on every cycle. A level line must take the written value. A data write of 0 must leave no pulse line high. An illegal code must leave the code stable, and the code must always stay within 0..9. A write to the unused address must leave the registers alone. A pulse line may rise only after a data write, and may fall only after a write or a tick. The exact pulse length for each code cannot be seen from a single cycle, so only the bench scenarios show it. The same holds for the non-restart on a repeated 1, the snapshot of the width at pulse start, the common ending of lines started together, and the level left behind when the select bit is cleared.

// File: rtl/pog_pkg.sv
package pog_pkg;

   localparam int unsigned POG_MAX_TICKS = 100000;
   localparam int          POG_CODE_W    = 4;
   localparam int          POG_CODE_MAX  = 9;
   localparam int          POG_CNT_W     = $clog2(POG_MAX_TICKS + 1);

   typedef enum logic [1:0] {
      POG_REG_DATA  = 2'd0,
      POG_REG_SEL   = 2'd1,
      POG_REG_WIDTH = 2'd2,
      POG_REG_NONE  = 2'd3
   } pog_reg_e;

   // Width code to tick count; callers only pass legal codes.
   function automatic logic [POG_CNT_W-1:0] pog_code_ticks(input logic [POG_CODE_W-1:0] code);
      logic [POG_CNT_W-1:0] t;
      case (code)
         4'd0:    t = POG_CNT_W'(1);
         4'd1:    t = POG_CNT_W'(10);
         4'd2:    t = POG_CNT_W'(100);
         4'd3:    t = POG_CNT_W'(1000);
         4'd4:    t = POG_CNT_W'(2000);
         4'd5:    t = POG_CNT_W'(5000);
         4'd6:    t = POG_CNT_W'(10000);
         4'd7:    t = POG_CNT_W'(20000);
         4'd8:    t = POG_CNT_W'(50000);
         default: t = POG_CNT_W'(100000);
      endcase
      return t;
   endfunction

endpackage

// File: rtl/pog_tick_gen.sv
module pog_tick_gen #(
   parameter int TICK_DIV = 50000
) (
   input  logic clk,
   input  logic rst_n,
   output logic tick
);
   localparam int DIV_W = (TICK_DIV > 1) ? $clog2(TICK_DIV) : 1;
   localparam logic [DIV_W-1:0] LAST = DIV_W'(TICK_DIV - 1);

   logic [DIV_W-1:0] div_cnt;

   always_ff @(posedge clk) begin
      if (!rst_n)
         div_cnt <= '0;
      else if (div_cnt == LAST)
         div_cnt <= '0;
      else
         div_cnt <= div_cnt + 1'b1;
   end

   assign tick = (div_cnt == LAST);
endmodule

// File: rtl/pog_code_reg.sv
module pog_code_reg
   import pog_pkg::*;
(
   input  logic                  clk,
   input  logic                  rst_n,
   input  logic                  we,
   input  logic [POG_CODE_W-1:0] wcode,
   output logic [POG_CODE_W-1:0] code_q,
   output logic [POG_CNT_W-1:0]  width_ticks
);
   logic legal;
   assign legal = (wcode <= POG_CODE_W'(POG_CODE_MAX));

   always_ff @(posedge clk) begin
      if (!rst_n)
         code_q <= '0;
      else if (we && legal)
         code_q <= wcode;
   end

   assign width_ticks = pog_code_ticks(code_q);
endmodule

// File: rtl/pog_bit_cell.sv
module pog_bit_cell #(
   parameter int CNT_W = 17
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             tick,
   input  logic             pulse_mode,
   input  logic             sel_drop,
   input  logic             data_we,
   input  logic             data_wbit,
   input  logic [CNT_W-1:0] load_ticks,
   output logic             bit_q
);
   logic [CNT_W-1:0] remain;
   logic             running;

   assign running = (remain != '0);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         bit_q  <= 1'b0;
         remain <= '0;
      end else if (data_we && !pulse_mode) begin
         bit_q  <= data_wbit;
         remain <= '0;
      end else if (data_we && !data_wbit) begin
         bit_q  <= 1'b0;
         remain <= '0;
      end else if (data_we && !running) begin
         bit_q  <= 1'b1;
         remain <= load_ticks;
      end else if (sel_drop) begin
         remain <= '0;
      end else if (running && tick) begin
         if (remain == CNT_W'(1)) begin
            bit_q  <= 1'b0;
            remain <= '0;
         end else begin
            remain <= remain - 1'b1;
         end
      end
   end
endmodule

// File: rtl/pulse_out_group.sv
module pulse_out_group
   import pog_pkg::*;
#(
   parameter int NBITS    = 32,
   parameter int TICK_DIV = 50000
) (
   input  logic                  clk,
   input  logic                  rst_n,
   input  logic                  wr_en,
   input  logic [1:0]            wr_addr,
   input  logic [NBITS-1:0]      wr_data,
   output logic [NBITS-1:0]      dout,
   output logic [NBITS-1:0]      sel_q,
   output logic [POG_CODE_W-1:0] code_q
);
   if (NBITS < POG_CODE_W) begin : g_bad_nbits
      $error("pulse_out_group: NBITS must be at least %0d", POG_CODE_W);
   end
   if (TICK_DIV < 1) begin : g_bad_div
      $error("pulse_out_group: TICK_DIV must be at least 1");
   end

   logic                 we_data, we_sel, we_width;
   logic                 ms_tick;
   logic [POG_CNT_W-1:0] width_ticks;
   logic [NBITS-1:0]     sel_drop;

   assign we_data  = wr_en && (pog_reg_e'(wr_addr) == POG_REG_DATA);
   assign we_sel   = wr_en && (pog_reg_e'(wr_addr) == POG_REG_SEL);
   assign we_width = wr_en && (pog_reg_e'(wr_addr) == POG_REG_WIDTH);

   always_ff @(posedge clk) begin
      if (!rst_n)
         sel_q <= '0;
      else if (we_sel)
         sel_q <= wr_data;
   end

   assign sel_drop = we_sel ? (sel_q & ~wr_data) : '0;

   pog_tick_gen #(.TICK_DIV(TICK_DIV)) u_tick (
      .clk   (clk),
      .rst_n (rst_n),
      .tick  (ms_tick)
   );

   pog_code_reg u_code (
      .clk         (clk),
      .rst_n       (rst_n),
      .we          (we_width),
      .wcode       (wr_data[POG_CODE_W-1:0]),
      .code_q      (code_q),
      .width_ticks (width_ticks)
   );

   for (genvar i = 0; i < NBITS; i++) begin : g_cell
      pog_bit_cell #(.CNT_W(POG_CNT_W)) u_cell (
         .clk        (clk),
         .rst_n      (rst_n),
         .tick       (ms_tick),
         .pulse_mode (sel_q[i]),
         .sel_drop   (sel_drop[i]),
         .data_we    (we_data),
         .data_wbit  (wr_data[i]),
         .load_ticks (width_ticks),
         .bit_q      (dout[i])
      );
   end
endmodule

// File: rtl/pulse_out_group_chk.sv
module pulse_out_group_chk #(
   parameter int NBITS = 32
) (
   input logic             clk,
   input logic             rst_n,
   input logic             wr_en,
   input logic [1:0]       wr_addr,
   input logic [NBITS-1:0] wr_data,
   input logic [NBITS-1:0] dout,
   input logic [NBITS-1:0] sel_q,
   input logic [3:0]       code_q,
   input logic             tick
);
   a_r2_level_follows: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && wr_addr == 2'd0) |=> ((dout & ~sel_q) == ($past(wr_data) & ~sel_q)));

   a_r7_zero_ends_pulse: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && wr_addr == 2'd0) |=> ((dout & sel_q & ~$past(wr_data)) == '0));

   a_r5_bad_code_kept: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && wr_addr == 2'd2 && wr_data[3:0] > 4'd9) |=> $stable(code_q));

   a_r4_code_in_range: assert property (@(posedge clk) disable iff (!rst_n)
      code_q <= 4'd9);

   a_r3_rise_needs_write: assert property (@(posedge clk) disable iff (!rst_n)
      (|(dout & ~$past(dout) & $past(sel_q))) |-> ($past(wr_en) && $past(wr_addr) == 2'd0));

   a_r3_fall_needs_cause: assert property (@(posedge clk) disable iff (!rst_n)
      (|(~dout & $past(dout) & $past(sel_q))) |-> ($past(wr_en) || $past(tick)));

   a_r11_spare_addr: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && wr_addr == 2'd3) |=> ($stable(sel_q) && $stable(code_q)));
endmodule

bind pulse_out_group pulse_out_group_chk #(.NBITS(NBITS)) u_chk (
   .clk     (clk),
   .rst_n   (rst_n),
   .wr_en   (wr_en),
   .wr_addr (wr_addr),
   .wr_data (wr_data),
   .dout    (dout),
   .sel_q   (sel_q),
   .code_q  (code_q),
   .tick    (ms_tick)
);

// File: tb/sim_pulse_out_group.sv
`timescale 1ns/1ps
module sim_pulse_out_group;
   localparam int NB = 32;
   localparam int NV = 8;
   localparam int VEC_CODE  [0:NV-1] = '{0, 1, 2, 3, 4, 5, 6, 9};
   localparam int VEC_TICKS [0:NV-1] = '{1, 10, 100, 1000, 2000, 5000, 10000, 100000};

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          wr_en = 1'b0;
   logic [1:0]    wr_addr = 2'd0;
   logic [NB-1:0] wr_data = '0;
   logic [NB-1:0] dout, sel_q;
   logic [3:0]    code_q;

   int  checks = 0;
   int  failures = 0;
   bit  done = 1'b0;

   always #10 clk = ~clk;

   pulse_out_group #(.NBITS(NB), .TICK_DIV(1)) u0 (
      .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
      .wr_data(wr_data), .dout(dout), .sel_q(sel_q), .code_q(code_q)
   );

   task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         failures++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   task automatic wr(input logic [1:0] a, input logic [NB-1:0] d);
      wr_en = 1'b1; wr_addr = a; wr_data = d;
      @(negedge clk);
      wr_en = 1'b0; wr_data = '0;
   endtask

   task automatic cyc(input int n);
      repeat (n) @(negedge clk);
   endtask

   initial begin
      repeat (190000) @(posedge clk);
      if (!done) begin
         failures++;
         $display("FAIL watchdog actual=running expected=finished");
         $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
         $finish;
      end
   end

   initial begin
      cyc(3);
      check("R1 dout", dout, '0);
      check("R1 sel", sel_q, '0);
      check("R1 code", 32'(code_q), 32'd0);
      rst_n = 1'b1;
      cyc(1);

      // R2: level lines
      wr(2'd0, 32'hA5A5_0F0F);
      check("R2 level a", dout, 32'hA5A5_0F0F);
      wr(2'd0, 32'h5A5A_F0F0);
      check("R2 level b", dout, 32'h5A5A_F0F0);
      cyc(5);
      check("R2 level hold", dout, 32'h5A5A_F0F0);
      wr(2'd0, '0);

      // R3/R4: vector walk over width codes
      for (int v = 0; v < NV; v++) begin
         wr(2'd2, NB'(VEC_CODE[v]));
         check("R4 code readback", 32'(code_q), 32'(VEC_CODE[v]));
         wr(2'd1, NB'(1) << v);
         wr(2'd0, NB'(1) << v);
         check("R3 pulse rises", 32'(dout[v]), 32'd1);
         cyc(VEC_TICKS[v] - 1);
         check("R4 still high at last tick", 32'(dout[v]), 32'd1);
         cyc(1);
         check("R3 self-cleared", dout, '0);
      end
      wr(2'd1, '0);

      // R4/R5: legal and illegal codes
      wr(2'd2, 32'd7);
      check("R4 code 7", 32'(code_q), 32'd7);
      wr(2'd2, 32'd8);
      check("R4 code 8", 32'(code_q), 32'd8);
      wr(2'd2, 32'd3);
      wr(2'd2, 32'd12);
      check("R5 code 12 ignored", 32'(code_q), 32'd3);
      wr(2'd2, 32'd15);
      check("R5 code 15 ignored", 32'(code_q), 32'd3);

      // R6: rewrite 1 does not restart
      wr(2'd2, 32'd2);
      wr(2'd1, 32'h1);
      wr(2'd0, 32'h1);
      cyc(50);
      wr(2'd0, 32'h1);
      cyc(48);
      check("R6 high before original end", 32'(dout[0]), 32'd1);
      cyc(1);
      check("R6 ends at original time", 32'(dout[0]), 32'd0);

      // R7: writing 0 ends pulse
      wr(2'd0, 32'h1);
      cyc(10);
      wr(2'd0, 32'h0);
      check("R7 ended by zero", 32'(dout[0]), 32'd0);

      // R8: code change during pulse
      wr(2'd2, 32'd1);
      wr(2'd0, 32'h1);
      wr(2'd2, 32'd3);
      cyc(8);
      check("R8 high at tick 10", 32'(dout[0]), 32'd1);
      cyc(1);
      check("R8 width unchanged", 32'(dout[0]), 32'd0);

      // R9: shared width, mixed with level lines
      wr(2'd2, 32'd1);
      wr(2'd1, 32'h0000_00F0);
      wr(2'd0, 32'h0F00_00F0);
      cyc(9);
      check("R9 all high", dout, 32'h0F00_00F0);
      cyc(1);
      check("R9 pulses end together", dout, 32'h0F00_0000);
      wr(2'd0, '0);

      // R10: drop select mid-pulse
      wr(2'd2, 32'd2);
      wr(2'd1, 32'h1);
      wr(2'd0, 32'h1);
      cyc(5);
      wr(2'd1, 32'h0);
      check("R10 kept after drop", 32'(dout[0]), 32'd1);
      cyc(200);
      check("R10 now a level", 32'(dout[0]), 32'd1);

      // R11: spare address
      wr(2'd1, 32'h0000_0F00);
      wr(2'd3, 32'hFFFF_FFFF);
      check("R11 dout", dout, 32'h1);
      check("R11 sel", sel_q, 32'h0000_0F00);
      check("R11 code", 32'(code_q), 32'd2);

      done = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end
endmodule